// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog timer that sits on a simple word-wide register bus. A 32-bit down-counter runs while the watchdog is enabled. Each time it reaches zero it reloads from a programmable interval and latches a raw interrupt flag. Software keeps the system alive by clearing that flag before the next expiry. If the counter reaches zero again while the flag is still set and the reset output is enabled, the block drives a one-cycle system-reset pulse.

All registers except the lock register can be guarded against stray writes. Writing a fixed key to the lock register opens them for writing, and writing any other value closes them. When the watchdog is disabled the counter freezes at its current value and later resumes from it. Writing the interval register reloads the counter at once. Clearing the interrupt restarts the counter from the interval.

Requests are accepted every cycle. A response follows exactly one cycle after each request and carries the read data and an error flag.

Top module: `wdt_lockable`

## Requirements
- R1: After reset the interval register (offset 0x00) and the counter (offset 0x04) both read 0xFFFFFFFF. Control (offset 0x08), raw status (offset 0x10) and the lock register (offset 0x18) read 0, so writes are open. `irq` and `wd_rst` are low.
- R2: Only a request with all four byte strobes set (`req_strb` = 4'hF) is legal. Any other strobe pattern returns `rsp_err` = 1 with read data 0 and changes no state.
- R3: A write of 0x1ACCE551 to the lock register opens writes, and a write of any other value closes them. The lock register reads 1 while closed and 0 while open. While closed, writes to every other register are ignored.
- R4: While control bit 0 is set, the counter decrements once per cycle. In the cycle it holds zero, it reloads the interval and sets raw status bit 0. A reload value L therefore gives an expiry every L+1 cycles.
- R5: While control bit 0 is clear, the counter holds its value. Setting bit 0 again resumes counting from the held value.
- R6: A write to the interval register also loads the counter with the written value on the next cycle.
- R7: A write to the interrupt-clear register (offset 0x0C) clears raw status and reloads the counter from the interval. That register reads as 0.
- R8: Writes to the counter, raw status and masked status (offset 0x14) registers are ignored.
- R9: Masked status and the `irq` output equal raw status ANDed with control bit 0.
- R10: When the counter expires while raw status is already set and control bit 1 is set, `wd_rst` is high for the following cycle. It is low otherwise.
- R11: Reads of word offsets 0x20 and above, and of the test-control register (offset 0x1C), return 0. Writes to them have no effect.
- R12: Every request gets `rsp_valid` on the next cycle. Read data reflects the state before any change made in the request cycle. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_strb | input | DATA_W/8 | Byte strobes; all must be set |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Illegal access size |
| irq | output | 1 | Masked interrupt |
| wd_rst | output | 1 | One-cycle system-reset pulse |

## Verification
The embedded properties check the following on every cycle:
- The counter freezes while disabled.
- A reload follows every interval write.
- Clearing the interrupt drops raw status.
- Raw status rises only from a zero count.
- A reset pulse needs a pending flag and the reset enable.
- Closed registers stay stable.
- Narrow accesses answer with an error.

Only the bench's scenarios show the full picture:
- The exact expiry period.
- Resumption from a held count.
- The lock key handshake from end to end.
- The read values of unmapped and write-only offsets.
- The interleaving of random bus traffic with expiries. For this, a cycle-accurate reference model is compared on every response.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned NREG = 8;
  localparam int unsigned IX_LOAD   = 0;
  localparam int unsigned IX_VALUE  = 1;
  localparam int unsigned IX_CTRL   = 2;
  localparam int unsigned IX_ICLR   = 3;
  localparam int unsigned IX_RAW    = 4;
  localparam int unsigned IX_MASKED = 5;
  localparam int unsigned IX_LOCK   = 6;
  localparam int unsigned IX_TEST   = 7;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic load_wr;
    logic clr_wr;
    logic en;
    logic rst_en;
  } cnt_ctl_t;
endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
#(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned STRB_W = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_word,
  input  logic [STRB_W-1:0] req_strb,
  input  logic              locked,
  output logic [NREG-1:0]   rd_sel,
  output logic [NREG-1:0]   wr_sel,
  output logic              acc_err
);
  localparam int unsigned IDX_W = $clog2(NREG);

  logic full_word;
  logic mapped;

  assign full_word = (req_strb == {STRB_W{1'b1}});
  assign mapped    = ((req_word >> IDX_W) == '0);
  assign acc_err   = req_valid && !full_word;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    logic hit;
    assign hit = req_valid && full_word && mapped &&
                 (req_word[IDX_W-1:0] == IDX_W'(i));
    assign rd_sel[i] = hit && !req_write;
    if (i == IX_LOCK) begin : g_lock
      assign wr_sel[i] = hit && req_write;
    end else begin : g_gated
      assign wr_sel[i] = hit && req_write && !locked;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter logic [DATA_W-1:0] LOAD_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_ctl_t          ctl,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] count,
  output logic              raw,
  output logic              wd_rst
);
  logic [DATA_W-1:0] count_d;
  logic              raw_d;
  logic              pulse_d;
  logic              expire;

  assign expire = ctl.en && (count == '0);

  always_comb begin
    count_d = count;
    raw_d   = raw;
    pulse_d = 1'b0;
    if (ctl.load_wr) begin
      count_d = wr_data;
    end else if (ctl.clr_wr) begin
      count_d = load_val;
      raw_d   = 1'b0;
    end else if (expire) begin
      count_d = load_val;
      raw_d   = 1'b1;
      pulse_d = raw && ctl.rst_en;
    end else if (ctl.en) begin
      count_d = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= LOAD_RESET;
      raw    <= 1'b0;
      wd_rst <= 1'b0;
    end else begin
      count  <= count_d;
      raw    <= raw_d;
      wd_rst <= pulse_d;
    end
  end

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !ctl.load_wr && !ctl.clr_wr) |=> $stable(count));
  a_r6_load_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load_wr |=> (count == $past(wr_data)));
  a_r7_clear_drops_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clr_wr && !ctl.load_wr) |=> !raw);
  a_r4_raw_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> ($past(count) == '0 && $past(ctl.en)));
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> ($past(raw) && $past(ctl.rst_en)));
endmodule

// File: rtl/wdt_regbus.sv
module wdt_regbus
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter logic [DATA_W-1:0] LOAD_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NREG-1:0]   rd_sel,
  input  logic [NREG-1:0]   wr_sel,
  input  logic              acc_err,
  input  logic [DATA_W-1:0] count,
  input  logic              raw,
  output logic [DATA_W-1:0] load_q,
  output logic [1:0]        ctrl_q,
  output logic              locked,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic [DATA_W-1:0] rdata_d;
  logic              lock_d;

  assign lock_d = (wdata != UNLOCK_KEY);

  always_comb begin
    rdata_d = '0;
    if (rd_sel[IX_LOAD])   rdata_d = load_q;
    if (rd_sel[IX_VALUE])  rdata_d = count;
    if (rd_sel[IX_CTRL])   rdata_d = DATA_W'(ctrl_q);
    if (rd_sel[IX_RAW])    rdata_d = DATA_W'(raw);
    if (rd_sel[IX_MASKED]) rdata_d = DATA_W'(raw && ctrl_q[0]);
    if (rd_sel[IX_LOCK])   rdata_d = DATA_W'(locked);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= LOAD_RESET;
    end else if (wr_sel[IX_LOAD]) begin
      load_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_sel[IX_CTRL]) begin
      ctrl_q <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
    end else if (wr_sel[IX_LOCK]) begin
      locked <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rdata_d;
      rsp_err   <= acc_err;
    end
  end

  a_r3_closed_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !wr_sel[IX_LOCK]) |=> ($stable(load_q) && $stable(ctrl_q)));
  a_r2_narrow_errors: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> (rsp_err && rsp_rdata == '0));
  a_r12_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter logic [DATA_W-1:0] LOAD_RESET = '1,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [STRB_W-1:0] req_strb,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              irq,
  output logic              wd_rst
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [1:0]        rst_sync;
  logic              rst_n_int;
  logic [NREG-1:0]   rd_sel;
  logic [NREG-1:0]   wr_sel;
  logic              acc_err;
  logic              locked;
  logic [DATA_W-1:0] load_q;
  logic [1:0]        ctrl_q;
  logic [DATA_W-1:0] count;
  logic              raw;
  cnt_ctl_t          ctl;
  logic              unused_addr_lsbs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign unused_addr_lsbs = ^req_addr[1:0];

  wdt_decode #(.WORD_W(WORD_W), .STRB_W(STRB_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_word  (req_addr[ADDR_W-1:2]),
    .req_strb  (req_strb),
    .locked    (locked),
    .rd_sel    (rd_sel),
    .wr_sel    (wr_sel),
    .acc_err   (acc_err)
  );

  wdt_regbus #(.DATA_W(DATA_W), .LOAD_RESET(LOAD_RESET)) u_regbus (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .wdata     (req_wdata),
    .rd_sel    (rd_sel),
    .wr_sel    (wr_sel),
    .acc_err   (acc_err),
    .count     (count),
    .raw       (raw),
    .load_q    (load_q),
    .ctrl_q    (ctrl_q),
    .locked    (locked),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  assign ctl.load_wr = wr_sel[IX_LOAD];
  assign ctl.clr_wr  = wr_sel[IX_ICLR];
  assign ctl.en      = ctrl_q[0];
  assign ctl.rst_en  = ctrl_q[1];

  wdt_counter #(.DATA_W(DATA_W), .LOAD_RESET(LOAD_RESET)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ctl      (ctl),
    .load_val (load_q),
    .wr_data  (req_wdata),
    .count    (count),
    .raw      (raw),
    .wd_rst   (wd_rst)
  );

  assign irq = raw && ctrl_q[0];

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> ctrl_q[0]);
endmodule

// File: tb/test_wdt_lockable.sv
module test_wdt_lockable;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [3:0]  req_strb;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err, irq, wd_rst;
  logic [31:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] last_rd;

  logic [31:0] m_load, m_cnt;
  logic [1:0]  m_ctrl;
  logic        m_raw, m_locked, m_pulse;

  wdt_lockable i_wdt_lockable (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq(irq), .wd_rst(wd_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [11:0] a);
    case (a[11:2])
      10'd0: return "R6";
      10'd1: return "R4";
      10'd3: return "R7";
      10'd5: return "R9";
      10'd6: return "R3";
      10'd2, 10'd4: return "R4";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a[11:2])
      10'd0: return m_load;
      10'd1: return m_cnt;
      10'd2: return {30'd0, m_ctrl};
      10'd4: return {31'd0, m_raw};
      10'd5: return {31'd0, m_raw & m_ctrl[0]};
      10'd6: return {31'd0, m_locked};
      default: return 32'd0;
    endcase
  endfunction

  // one bus cycle; entered and left at a falling edge
  task automatic bus(input bit v, input bit w, input logic [11:0] a, input logic [3:0] s, input logic [31:0] d);
    bit ok_w, full;
    logic [31:0] exp_rd;
    logic [9:0] ix;
    req_valid = v; req_write = w; req_addr = a; req_strb = s; req_wdata = d;
    full = (s == 4'hF);
    ix = a[11:2];
    exp_rd = (v && full && !w) ? model_read(a) : 32'd0;
    ok_w = v && w && full;
    m_pulse = 1'b0;
    if (ok_w && ix == 10'd6) m_locked = (d != KEY);
    else if (ok_w && !m_locked && ix == 10'd2) m_ctrl = d[1:0];
    if (ok_w && !m_locked && ix == 10'd0) begin
      m_load = d; m_cnt = d;
    end else if (ok_w && !m_locked && ix == 10'd3) begin
      m_cnt = m_load; m_raw = 1'b0;
    end else if (m_ctrl_pre_en) begin
      if (m_cnt == 0) begin
        m_pulse = m_raw & m_rst_pre; m_cnt = m_load; m_raw = 1'b1;
      end else m_cnt = m_cnt - 1;
    end
    @(negedge clk);
    chk(rsp_valid == v, "R12 rsp_valid", {31'd0, rsp_valid}, {31'd0, v});
    if (v) begin
      chk(rsp_err == (v && !full), "R2 rsp_err", {31'd0, rsp_err}, {31'd0, !full});
      chk(rsp_rdata == exp_rd, tag_of(a), rsp_rdata, exp_rd);
      last_rd = rsp_rdata;
    end
    chk(irq == (m_raw & m_ctrl[0]), "R9 irq", {31'd0, irq}, {31'd0, m_raw & m_ctrl[0]});
    chk(wd_rst == m_pulse, "R10 wd_rst", {31'd0, wd_rst}, {31'd0, m_pulse});
    m_ctrl_pre_en = m_ctrl[0];
    m_rst_pre = m_ctrl[1];
  endtask

  logic m_ctrl_pre_en, m_rst_pre;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus(1'b1, 1'b1, a, 4'hF, d);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus(1'b1, 1'b0, a, 4'hF, 32'd0);
    chk(last_rd == exp, tag, last_rd, exp);
  endtask

  initial begin
    int s;
    s = $urandom(32'd7);
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] held;
    req_valid = 0; req_write = 0; req_addr = 0; req_strb = 0; req_wdata = 0;
    m_load = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF; m_ctrl = 0; m_raw = 0;
    m_locked = 0; m_pulse = 0; m_ctrl_pre_en = 0; m_rst_pre = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!irq && !wd_rst && !rsp_valid, "R1 outputs", {29'd0, irq, wd_rst, rsp_valid}, 32'd0);
    rd_chk(12'h000, 32'hFFFF_FFFF, "R1 load");
    rd_chk(12'h004, 32'hFFFF_FFFF, "R1 value");
    rd_chk(12'h008, 32'd0, "R1 ctrl");
    rd_chk(12'h010, 32'd0, "R1 raw");
    rd_chk(12'h018, 32'd0, "R1 lock");

    // R2 narrow accesses
    bus(1'b1, 1'b1, 12'h000, 4'h3, 32'd5);
    chk(rsp_err == 1'b1, "R2 narrow write err", {31'd0, rsp_err}, 32'd1);
    rd_chk(12'h000, 32'hFFFF_FFFF, "R2 load unchanged");
    bus(1'b1, 1'b0, 12'h000, 4'h1, 32'd0);
    chk(rsp_err && rsp_rdata == 0, "R2 narrow read", rsp_rdata, 32'd0);

    // R6 load reloads counter
    wr(12'h000, 32'd3);
    rd_chk(12'h004, 32'd3, "R6 value after load");

    // R4 countdown and expiry
    wr(12'h008, 32'd1);
    rd_chk(12'h004, 32'd3, "R4 count 3");
    rd_chk(12'h004, 32'd2, "R4 count 2");
    rd_chk(12'h004, 32'd1, "R4 count 1");
    rd_chk(12'h004, 32'd0, "R4 count 0");
    rd_chk(12'h004, 32'd3, "R4 reload");
    rd_chk(12'h010, 32'd1, "R4 raw set");
    rd_chk(12'h014, 32'd1, "R9 masked");
    chk(irq == 1'b1, "R9 irq high", {31'd0, irq}, 32'd1);

    // R7 interrupt clear
    wr(12'h00C, 32'd0);
    rd_chk(12'h010, 32'd0, "R7 raw cleared");
    rd_chk(12'h00C, 32'd0, "R7 clear reads zero");

    // R5 hold while disabled, resume
    wr(12'h008, 32'd0);
    bus(1'b1, 1'b0, 12'h004, 4'hF, 32'd0);
    held = last_rd;
    rd_chk(12'h004, held, "R5 held");
    wr(12'h008, 32'd1);
    rd_chk(12'h004, held, "R5 resume from held");

    // R10 reset pulse
    wr(12'h000, 32'd0);
    wr(12'h008, 32'd3);
    bus(1'b0, 1'b0, 12'h0, 4'h0, 32'd0);
    bus(1'b0, 1'b0, 12'h0, 4'h0, 32'd0);
    chk(wd_rst == 1'b1, "R10 pulse asserted", {31'd0, wd_rst}, 32'd1);
    wr(12'h008, 32'd1);
    bus(1'b0, 1'b0, 12'h0, 4'h0, 32'd0);
    bus(1'b0, 1'b0, 12'h0, 4'h0, 32'd0);
    chk(wd_rst == 1'b0, "R10 no pulse without enable", {31'd0, wd_rst}, 32'd0);

    // R8 read-only registers
    wr(12'h008, 32'd0);
    wr(12'h000, 32'd10);
    wr(12'h004, 32'h55);
    rd_chk(12'h004, 32'd10, "R8 value ignores write");
    wr(12'h010, 32'd0);
    wr(12'h014, 32'd0);
    rd_chk(12'h010, 32'd1, "R8 raw ignores write");

    // R3 lock
    wr(12'h018, 32'd0);
    rd_chk(12'h018, 32'd1, "R3 lock reads 1");
    wr(12'h000, 32'd7);
    rd_chk(12'h000, 32'd10, "R3 locked load");
    wr(12'h00C, 32'd0);
    rd_chk(12'h010, 32'd1, "R3 locked clear");
    wr(12'h018, KEY);
    rd_chk(12'h018, 32'd0, "R3 unlocked");
    wr(12'h000, 32'd7);
    rd_chk(12'h000, 32'd7, "R3 write after unlock");

    // R11 unmapped and test control
    wr(12'h040, 32'hDEAD_BEEF);
    rd_chk(12'h040, 32'd0, "R11 unmapped read");
    wr(12'h01C, 32'hFFFF_FFFF);
    rd_chk(12'h01C, 32'd0, "R11 test ctrl");
    rd_chk(12'h000, 32'd7, "R11 no side effect");

    // R12 low address bits ignored
    rd_chk(12'h003, 32'd7, "R12 unaligned");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0] st;
      bit v, w;
      v = ($urandom % 10) < 7;
      w = $urandom % 2;
      a = {($urandom % 12 < 9) ? 10'($urandom % 8) : 10'(8 + $urandom % 8), 2'($urandom % 4)};
      st = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
      d = $urandom;
      if (a[11:2] == 10'd0) d = $urandom % 12;
      if (a[11:2] == 10'd6) d = ($urandom % 3 == 0) ? 32'd0 : KEY;
      bus(v, w, a, st, d);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule